// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a single-cycle 32-bit processor and works out the address of the next instruction every cycle. From the current instruction word, the ALU equality flag and the decoder's branch and jump strobes, it forms three candidate addresses. The first is the sequential successor, the PC plus four. The second is a PC-relative branch target built from a signed 16-bit word offset. The third is a region-relative jump target built from a 26-bit word index. One of the three is loaded into the PC at the next clock edge.

Selection runs through two cascaded multiplexers. The first chooses between the sequential address and the branch target. The second chooses between that result and the jump target, so a jump always takes priority. The PC has no write enable and moves on every edge. A synchronous, active-high reset loads it with a parameterised start address, which is zero by default. The next address is also brought out combinationally, so the fetch side can look ahead one cycle.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` becomes RESET_PC (default 0) after that edge.
- R2: With `jmp_en` low and not (`br_en` and `alu_zero`), the PC advances to PC+4 on every rising edge, with no enable needed.
- R3: With `br_en` and `alu_zero` both high and `jmp_en` low, the next PC is PC+4 plus instruction bits [15:0], sign-extended from bit 15 and shifted left by two.
- R4: A branch is not taken when only one of `br_en` and `alu_zero` is high; the next PC is then PC+4.
- R5: Negative branch offsets wrap modulo 2^32. An offset field of 16'hFFFF targets the current PC itself, and 16'h8000 moves back 0x20000-4 bytes from the current PC.
- R6: With `jmp_en` high, the next PC is {(PC+4)[31:28], instruction bits [25:0], 2'b00}.
- R7: `jmp_en` takes priority over a taken branch.
- R8: `next_pc_o` always shows, in the same cycle, the value that `pc_o` takes at the next rising edge.
- R9: The upper four bits used for a jump come from PC+4, not from PC. From PC = 0x0FFFFFFC, a jump lands in region 0x1. From PC = 0xFFFFFFFC, the sequential successor wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word fetched at the current PC |
| alu_zero_i | input | 1 | ALU result-is-zero flag (operands equal) |
| br_en_i | input | 1 | Decoder strobe for a conditional branch |
| jmp_en_i | input | 1 | Decoder strobe for an absolute jump |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address the PC loads at the next edge |

## Verification
`next_pc_o` is combinational, so its value is due in the same cycle as the stimulus. The bench changes inputs on the falling edge and samples it one time unit later. `pc_o` passes through one register, so it is due one rising edge after the stimulus. The bench samples it at the following falling edge and compares it against its own arithmetic model of the three targets and of the priority rule. Every stimulus cycle therefore gives two comparisons, one at each latency. The PC is steered to the region and wrap-around corners by jumps and by a large backward branch.

// File: rtl/npc_pkg.sv
package npc_pkg;

    parameter int ADDR_W   = 32;
    parameter int INSTR_W  = 32;
    parameter int OFF_W    = 16;
    parameter int IDX_W    = 26;
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = ADDR_W - IDX_W - ALIGN_W;
    localparam int SEXT_W   = ADDR_W - OFF_W - ALIGN_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } npc_src_e;

    typedef struct packed {
        addr_t seq;
        addr_t branch;
        addr_t jump;
    } npc_targets_t;

    function automatic addr_t word_offset(input logic [OFF_W-1:0] off);
        return {{SEXT_W{off[OFF_W-1]}}, off, {ALIGN_W{1'b0}}};
    endfunction

    function automatic addr_t region_target(input addr_t base,
                                            input logic [IDX_W-1:0] idx);
        return {base[ADDR_W-1 -: REGION_W], idx, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_target_calc.sv
module npc_target_calc
    import npc_pkg::*;
(
    input  addr_t                 pc_i,
    input  logic [INSTR_W-1:0]    instr_i,
    output npc_targets_t          tgt_o
);
    localparam addr_t STEP = addr_t'(4);

    addr_t seq_addr;
    logic  unused_opcode;

    assign seq_addr      = pc_i + STEP;
    assign unused_opcode = ^instr_i[INSTR_W-1:IDX_W];

    always_comb begin
        tgt_o.seq    = seq_addr;
        tgt_o.branch = seq_addr + word_offset(instr_i[OFF_W-1:0]);
        tgt_o.jump   = region_target(seq_addr, instr_i[IDX_W-1:0]);
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  npc_targets_t tgt_i,
    input  logic         br_en_i,
    input  logic         alu_zero_i,
    input  logic         jmp_en_i,
    output addr_t        next_o,
    output npc_src_e     src_o
);
    logic  take_branch;
    addr_t stage1;

    assign take_branch = br_en_i & alu_zero_i;

    // First mux: sequential vs branch
    assign stage1 = take_branch ? tgt_i.branch : tgt_i.seq;
    // Second mux: jump overrides stage one
    assign next_o = jmp_en_i ? tgt_i.jump : stage1;

    always_comb begin
        if (jmp_en_i)         src_o = SRC_JUMP;
        else if (take_branch) src_o = SRC_BRANCH;
        else                  src_o = SRC_SEQ;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr_i,
    input  logic        alu_zero_i,
    input  logic        br_en_i,
    input  logic        jmp_en_i,
    output logic [31:0] pc_o,
    output logic [31:0] next_pc_o
);
    addr_t        pc_q;
    addr_t        next_pc;
    npc_targets_t tgts;
    npc_src_e     src;

    npc_target_calc u_calc (
        .pc_i    (pc_q),
        .instr_i (instr_i),
        .tgt_o   (tgts)
    );

    npc_select u_sel (
        .tgt_i      (tgts),
        .br_en_i    (br_en_i),
        .alu_zero_i (alu_zero_i),
        .jmp_en_i   (jmp_en_i),
        .next_o     (next_pc),
        .src_o      (src)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= next_pc;
    end

    assign pc_o      = pc_q;
    assign next_pc_o = next_pc;

    p_reset_r1: assert property (@(posedge clk) rst |=> pc_q == RESET_PC);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!jmp_en_i && !(br_en_i && alu_zero_i)) |=> pc_q == $past(pc_q) + 32'd4);

    p_branch_delta_r3: assert property (@(posedge clk) disable iff (rst)
        (br_en_i && alu_zero_i && !jmp_en_i) |=>
        (pc_q - $past(pc_q) - 32'd4) ==
        {{14{$past(instr_i[15])}}, $past(instr_i[15:0]), 2'b00});

    p_jump_fields_r6: assert property (@(posedge clk) disable iff (rst)
        jmp_en_i |=> (pc_q[27:0] == {$past(instr_i[25:0]), 2'b00}) &&
                     (pc_q[31:28] == $past(tgts.seq[31:28])));

    p_jump_wins_r7: assert property (@(posedge clk) disable iff (rst)
        jmp_en_i |-> src == SRC_JUMP);

    p_lookahead_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_q == $past(next_pc_o));
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        zero = 1'b0, br = 1'b0, jmp = 1'b0;
    logic [31:0] pc_o, next_pc_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] model_pc;
    bit done = 0;

    npc_unit u_dut (
        .clk(clk), .rst(rst), .instr_i(instr), .alu_zero_i(zero),
        .br_en_i(br), .jmp_en_i(jmp), .pc_o(pc_o), .next_pc_o(next_pc_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_next(input logic [31:0] pc, input logic [31:0] ins,
                                                input logic b, input logic z, input logic j);
        logic [31:0] p4, boff;
        p4   = pc + 32'd4;
        boff = 32'(signed'(ins[15:0])) * 32'd4;
        if (j)          return {p4[31:28], ins[25:0], 2'b00};
        else if (b & z) return p4 + boff;
        else            return p4;
    endfunction

    function automatic string tag_of(input logic [31:0] ins, input logic b,
                                     input logic z, input logic j);
        if (j && b && z)   return "R7";
        if (j)             return "R6";
        if (b && z)        return ins[15] ? "R5" : "R3";
        if (b || z)        return "R4";
        return "R2";
    endfunction

    // Called at a falling edge; leaves at the next falling edge.
    task automatic step(input logic [31:0] ins, input logic b, input logic z,
                        input logic j, input string req);
        logic [31:0] exp;
        instr = ins; br = b; zero = z; jmp = j;
        #1;
        exp = expect_next(model_pc, ins, b, z, j);
        check(next_pc_o, exp, "R8");
        @(posedge clk);
        model_pc = exp;
        @(negedge clk);
        check(pc_o, model_pc, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc_o, 32'h0, "R1");
        model_pc = 32'h0;
        rst = 1'b0;

        // R2: plain sequential stepping
        for (int i = 0; i < 8; i++) step(32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, "R2");

        // R5: offset -1 targets the current PC
        step(32'h1000_FFFF, 1'b1, 1'b1, 1'b0, "R5");
        check(pc_o, 32'h20, "R5");

        // Near-exhaustive sweep of control combinations over many words
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] w;
            logic [2:0]  c;
            w = $urandom;
            c = 3'(k);
            step(w, c[0], c[1], c[2], tag_of(w, c[0], c[1], c[2]));
        end

        // Offset boundaries: most negative and most positive
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        model_pc = 32'h0;
        check(pc_o, 32'h0, "R1");
        step(32'h0000_8000, 1'b1, 1'b1, 1'b0, "R5");
        check(pc_o, 32'hFFFE_0004, "R5");
        step(32'h0000_7FFF, 1'b1, 1'b1, 1'b0, "R3");
        check(pc_o, 32'h0000_0004, "R3");

        // R9: wrap at the top of the address space
        step(32'h03FF_FFFF, 1'b0, 1'b0, 1'b1, "R6");
        check(pc_o, 32'h0FFF_FFFC, "R9");
        step(32'h0000_0000, 1'b0, 1'b0, 1'b1, "R9");
        check(pc_o, 32'h1000_0000, "R9");
        step(32'h0000_8000, 1'b1, 1'b1, 1'b0, "R5");
        step(32'h03FF_FFFF, 1'b0, 1'b0, 1'b1, "R6");
        check(pc_o, 32'h0FFF_FFFC, "R9");
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        model_pc = 32'h0;
        step(32'h0000_8000, 1'b1, 1'b1, 1'b0, "R5");
        step(32'h03FF_FFFF, 1'b0, 1'b0, 1'b1, "R6");
        check(pc_o, 32'hFFFF_FFFC, "R9");
        step(32'h0, 1'b0, 1'b0, 1'b0, "R9");
        check(pc_o, 32'h0, "R9");

        // R7: jump over a taken branch
        step(32'h0000_0010, 1'b1, 1'b1, 1'b1, "R7");
        check(pc_o, 32'h0000_0040, "R7");
        // R4: lone strobes do not branch
        step(32'h0000_0100, 1'b1, 1'b0, 1'b0, "R4");
        check(pc_o, 32'h0000_0044, "R4");
        step(32'h0000_0100, 1'b0, 1'b1, 1'b0, "R4");
        check(pc_o, 32'h0000_0048, "R4");

        done = 1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule